// File: doc/BRIEF.md
# Operand Forwarding Control and Select

This block decides, for each of the two ALU operands of the instruction now in the execute stage of a five-stage pipeline, where the operand should come from. It compares both source register numbers of that instruction with the destination registers of the two older instructions still in flight. The first is one stage ahead, at the ALU-result stage. The second is two stages ahead, at the writeback stage. The block drives a 2-bit select for each operand and applies it in a 3-input operand mux.

The block is purely combinational. Its operands are register numbers and data words that the pipeline registers around it already hold. There is no stream here, so there is no valid/ready handshake and no back-pressure. A producer that is one stage ahead is younger than one that is two stages ahead, so it has priority. Register zero is never forwarded, and an instruction that does not write a register is never forwarded either.

A hazard against an instruction that is three stages ahead is resolved elsewhere, by a register file that passes a same-cycle write straight through to its read port. Stall insertion is done outside this block.

Top module: `operand_fwd_unit`

## Requirements
- R1: Select A is 2'b10 when the ALU-result-stage instruction writes a register, its destination is not zero, and that destination equals source A.
- R2: Select B is 2'b10 under the same condition applied to source B.
- R3: When R1 (or R2) does not apply, select A (or B) is 2'b01 when the writeback-stage instruction writes a register, its destination is not zero, and that destination equals the source.
- R4: When both stages match the same nonzero source, the ALU-result stage wins and the select is 2'b10.
- R5: A source of register zero always gives select 2'b00, even when a destination is also zero and its write enable is set.
- R6: A stage whose write enable is low never causes forwarding. With no match the select is 2'b00.
- R7: Each operand output equals the register-file value for select 2'b00, the ALU-result-stage result for 2'b10, and the writeback data for 2'b01.
- R8: The writeback data is the loaded memory word when the writeback-stage load flag is high, and that stage's ALU result otherwise.
- R9: The select for one operand depends only on its own source number. Changing source B never changes select A, and changing source A never changes select B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | RAW | Source register A of the execute-stage instruction |
| ex_src_b | input | RAW | Source register B of the execute-stage instruction |
| rf_val_a | input | DW | Register-file value read for source A |
| rf_val_b | input | DW | Register-file value read for source B |
| am_wr_en | input | 1 | ALU-result-stage instruction writes a register |
| am_dst | input | RAW | ALU-result-stage destination register |
| am_result | input | DW | ALU-result-stage ALU result |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | RAW | Writeback-stage destination register |
| wb_is_load | input | 1 | Writeback-stage instruction is a load |
| wb_load_word | input | DW | Word loaded from memory in the writeback stage |
| wb_alu_result | input | DW | Writeback-stage ALU result |
| sel_a | output | 2 | Operand A select: 00 register file, 10 ALU-result stage, 01 writeback |
| sel_b | output | 2 | Operand B select, same encoding as sel_a |
| opnd_a | output | DW | Selected operand A |
| opnd_b | output | DW | Selected operand B |

## Verification
The bench builds several directed cases:
- Both stages naming the same source. A design with the priority reversed returns the older, stale value there.
- Register zero as the source, with enabled stages whose destination is also zero. A design missing the zero guard forwards garbage into reads of the hardwired zero.
- Matching destinations with the write enable low. A design ignoring the enable forwards results of stores and branches.
- Loads against non-loads at writeback, together with sources that differ between A and B. These expose a swapped writeback data choice or cross-wired operands.

Random traffic over a small register range then makes partial and double matches frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_AM  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// One comparator: does a producing stage supply this source register?
module fwd_match #(
  parameter int RAW = 5
) (
  input  logic           wr_en,
  input  logic [RAW-1:0] dst,
  input  logic [RAW-1:0] src,
  output logic           hit
);
  logic dst_nonzero;
  assign dst_nonzero = |dst;
  assign hit = wr_en && dst_nonzero && (dst == src);
endmodule

// File: rtl/fwd_prio.sv
// Youngest producer wins.
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     am_hit,
  input  logic     wb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (am_hit)      sel = SEL_AM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  fwd_sel_e      sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] am_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (sel)
      SEL_AM:  y = am_val;
      SEL_WB:  y = wb_val;
      default: y = rf_val;
    endcase
  end
endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
  import fwd_pkg::*;
#(
  parameter int RAW = 5,
  parameter int DW  = 32
) (
  input  logic [RAW-1:0] ex_src_a,
  input  logic [RAW-1:0] ex_src_b,
  input  logic [DW-1:0]  rf_val_a,
  input  logic [DW-1:0]  rf_val_b,
  input  logic           am_wr_en,
  input  logic [RAW-1:0] am_dst,
  input  logic [DW-1:0]  am_result,
  input  logic           wb_wr_en,
  input  logic [RAW-1:0] wb_dst,
  input  logic           wb_is_load,
  input  logic [DW-1:0]  wb_load_word,
  input  logic [DW-1:0]  wb_alu_result,
  output logic [1:0]     sel_a,
  output logic [1:0]     sel_b,
  output logic [DW-1:0]  opnd_a,
  output logic [DW-1:0]  opnd_b
);
  localparam int NOPND = 2;

  logic [DW-1:0]  wb_data;
  logic [RAW-1:0] src   [NOPND];
  logic [DW-1:0]  rfv   [NOPND];
  fwd_sel_e       sel   [NOPND];
  logic [DW-1:0]  opnd  [NOPND];

  assign wb_data = wb_is_load ? wb_load_word : wb_alu_result;

  assign src[0] = ex_src_a;
  assign src[1] = ex_src_b;
  assign rfv[0] = rf_val_a;
  assign rfv[1] = rf_val_b;

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    logic am_hit, wb_hit;
    fwd_match #(.RAW(RAW)) u_am_cmp (
      .wr_en(am_wr_en), .dst(am_dst), .src(src[i]), .hit(am_hit));
    fwd_match #(.RAW(RAW)) u_wb_cmp (
      .wr_en(wb_wr_en), .dst(wb_dst), .src(src[i]), .hit(wb_hit));
    fwd_prio u_prio (.am_hit(am_hit), .wb_hit(wb_hit), .sel(sel[i]));
    fwd_mux #(.DW(DW)) u_mux (
      .sel(sel[i]), .rf_val(rfv[i]), .am_val(am_result),
      .wb_val(wb_data), .y(opnd[i]));
  end

  assign sel_a  = sel[0];
  assign sel_b  = sel[1];
  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];
endmodule

// File: rtl/operand_fwd_checker.sv
module operand_fwd_checker #(
  parameter int RAW = 5,
  parameter int DW  = 32
) (
  input logic [RAW-1:0] ex_src_a,
  input logic [RAW-1:0] ex_src_b,
  input logic [DW-1:0]  rf_val_a,
  input logic [DW-1:0]  rf_val_b,
  input logic           am_wr_en,
  input logic [RAW-1:0] am_dst,
  input logic [DW-1:0]  am_result,
  input logic           wb_wr_en,
  input logic [RAW-1:0] wb_dst,
  input logic           wb_is_load,
  input logic [DW-1:0]  wb_load_word,
  input logic [DW-1:0]  wb_alu_result,
  input logic [1:0]     sel_a,
  input logic [1:0]     sel_b,
  input logic [DW-1:0]  opnd_a,
  input logic [DW-1:0]  opnd_b
);
  logic known;
  assign known = !$isunknown({ex_src_a, ex_src_b, am_wr_en, am_dst,
                              wb_wr_en, wb_dst, wb_is_load});

  always_comb begin
    if (known) begin
      if (am_wr_en && am_dst != '0 && am_dst == ex_src_a)
        assert_am_fwd_a_R1: assert (sel_a == 2'b10);
      if (am_wr_en && am_dst != '0 && am_dst == ex_src_b)
        assert_am_fwd_b_R2: assert (sel_b == 2'b10);
      if (ex_src_a == '0)
        assert_zero_src_R5: assert (sel_a == 2'b00);
      if (!am_wr_en && !wb_wr_en)
        assert_no_writer_R6: assert (sel_a == 2'b00 && sel_b == 2'b00);
      if (sel_a == 2'b01)
        assert_wb_data_R8: assert (opnd_a == (wb_is_load ? wb_load_word : wb_alu_result));
      if (sel_b == 2'b00)
        assert_rf_path_R7: assert (opnd_b == rf_val_b);
      assert_sel_legal_R3: assert (sel_a != 2'b11 && sel_b != 2'b11);
    end
  end
endmodule

bind operand_fwd_unit operand_fwd_checker #(.RAW(RAW), .DW(DW)) u_chk (.*);

// File: tb/operand_fwd_unit_tb.sv
module operand_fwd_unit_tb;
  localparam int RAW = 5;
  localparam int DW  = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [RAW-1:0] ex_src_a, ex_src_b, am_dst, wb_dst;
  logic [DW-1:0]  rf_val_a, rf_val_b, am_result, wb_load_word, wb_alu_result;
  logic           am_wr_en, wb_wr_en, wb_is_load;
  logic [1:0]     sel_a, sel_b;
  logic [DW-1:0]  opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  operand_fwd_unit #(.RAW(RAW), .DW(DW)) u_dut (.*);

  function automatic logic [1:0] exp_sel(logic [RAW-1:0] s);
    if (am_wr_en && am_dst != 0 && am_dst == s) return 2'b10;
    if (wb_wr_en && wb_dst != 0 && wb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] exp_op(logic [1:0] s, logic [DW-1:0] rf);
    case (s)
      2'b10:   return am_result;
      2'b01:   return wb_is_load ? wb_load_word : wb_alu_result;
      default: return rf;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply_and_check(string tag);
    logic [1:0] ea, eb;
    @(posedge clk);
    #1;
    @(negedge clk);
    ea = exp_sel(ex_src_a);
    eb = exp_sel(ex_src_b);
    chk(tag, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    chk(tag, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    chk({tag, " R7"}, "opnd_a", opnd_a, exp_op(ea, rf_val_a));
    chk({tag, " R7"}, "opnd_b", opnd_b, exp_op(eb, rf_val_b));
  endtask

  task automatic set_stages(logic ae, logic [RAW-1:0] ad, logic we, logic [RAW-1:0] wd, logic ld);
    am_wr_en = ae; am_dst = ad; wb_wr_en = we; wb_dst = wd; wb_is_load = ld;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] sa_hold;
    void'($urandom(32'd1234));
    rf_val_a = 32'hAAAA_0001; rf_val_b = 32'hBBBB_0002;
    am_result = 32'h1111_1111; wb_load_word = 32'h2222_2222; wb_alu_result = 32'h3333_3333;
    ex_src_a = 5'd0; ex_src_b = 5'd0;
    set_stages(0, 0, 0, 0, 0);
    apply_and_check("R6 idle");

    ex_src_a = 5'd3; ex_src_b = 5'd4;
    set_stages(1, 5'd3, 0, 5'd0, 0);
    apply_and_check("R1");
    set_stages(1, 5'd4, 0, 5'd0, 0);
    apply_and_check("R2");
    set_stages(0, 5'd0, 1, 5'd3, 0);
    apply_and_check("R3 R8 alu");
    set_stages(0, 5'd0, 1, 5'd4, 1);
    apply_and_check("R3 R8 load");
    set_stages(1, 5'd3, 1, 5'd3, 1);
    apply_and_check("R4");
    ex_src_a = 5'd0; ex_src_b = 5'd0;
    set_stages(1, 5'd0, 1, 5'd0, 1);
    apply_and_check("R5");
    ex_src_a = 5'd7; ex_src_b = 5'd7;
    set_stages(0, 5'd7, 0, 5'd7, 0);
    apply_and_check("R6");

    ex_src_a = 5'd9; ex_src_b = 5'd2;
    set_stages(1, 5'd9, 1, 5'd2, 0);
    apply_and_check("R9 base");
    sa_hold = sel_a;
    ex_src_b = 5'd9;
    apply_and_check("R9");
    chk("R9", "sel_a unchanged", {30'd0, sel_a}, {30'd0, sa_hold});

    for (int i = 0; i < 3000; i++) begin
      ex_src_a = RAW'($urandom_range(0, 3));
      ex_src_b = RAW'($urandom_range(0, 3));
      set_stages(1'($urandom), RAW'($urandom_range(0, 3)),
                 1'($urandom), RAW'($urandom_range(0, 3)), 1'($urandom));
      rf_val_a = $urandom; rf_val_b = $urandom;
      am_result = $urandom; wb_load_word = $urandom; wb_alu_result = $urandom;
      apply_and_check("random R1,R2,R3,R4,R5,R6,R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule